// File: doc/BRIEF.md
# Nonvolatile Transfer Handshake Controller

This controller sequences the transfers between a static RAM array and its nonvolatile shadow. An external agent asks for a save by pulling a shared active-low line. The controller waits a fixed grace period. During that period reads go on and an in-flight write may finish, but no new write may start. The save then runs only if the array holds data written since the last transfer. The same line carries the controller's own busy indication. The controller pulls it low for as long as any save runs, including one started by the software address sequence. That sequence is decoded elsewhere and arrives here as a one-cycle strobe.

A power-good input stands in for the supply comparator. While power is absent, or after reset, a restore request is held pending and all array accesses are blocked. Once power is good again, a restore of fixed length runs automatically. Accesses stay blocked for the whole restore.

The shared line is modelled as a raw input plus an output enable. The input passes through a two-stage synchroniser before the sequencer uses it. All durations are parameters counted in clock cycles.

Top module: `nv_xfer_ctrl`

## Requirements
- R1: After reset with power not good, the block holds a restore pending: write enable, read enable, save and restore indications and busy drive are all low.
- R2: When power becomes good while a restore is pending, the restore indication is high for exactly RESTORE_CYC cycles starting one cycle later, after which write and read enable return high.
- R3: A low level on the shared line reaches the sequencer after the two-flop synchroniser. The save indication rises DELAY_CYC+3 cycles after the line falls and stays high for SAVE_CYC cycles, provided the dirty flag is set when the grace period ends.
- R4: During the grace period read enable stays high and write enable is low. A write completion that arrives during the grace period still sets the dirty flag, and the save then runs.
- R5: A line-requested save with the dirty flag clear performs no save: the save indication and busy drive stay low.
- R6: A software save strobe in the idle state starts the save one cycle later, for SAVE_CYC cycles, whether or not the dirty flag is set.
- R7: Busy drive is high in exactly the cycles in which a save runs, and both access enables are low while it is high.
- R8: After a save, or after a grace period that ends without a save, both enables stay low until the synchronised line is high again. Write enable returns three cycles after the line is released.
- R9: The dirty flag (output `dirty`) is set one cycle after a write completion pulse. It is cleared in the cycle a save or restore starts.
- R10: Power going not good in any state ends a running save or restore on the next cycle. A restore then runs once power is good again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_n_in | input | 1 | Raw level of the shared request/busy line |
| busy_oe | output | 1 | When high, the line is pulled low (save in progress) |
| sw_save | input | 1 | One-cycle strobe from the software sequence decoder |
| pwr_good | input | 1 | Supply above the switch threshold, already synchronous |
| wr_done | input | 1 | One-cycle pulse when an array write completes |
| wr_en | output | 1 | New array writes may start |
| rd_en | output | 1 | Array reads may proceed |
| nv_save | output | 1 | Save to the nonvolatile shadow is running |
| nv_restore | output | 1 | Restore from the nonvolatile shadow is running |
| dirty | output | 1 | A write has completed since the last save or restore |

## Verification
Inputs change on the falling clock edge, and outputs are sampled on later falling edges, counted from the stimulus edge. A software strobe or a power-good rise shows at sample 1. A line request shows at sample DELAY_CYC+3: two synchroniser stages, one sequencer edge, then the grace count. A line release re-enables writes at sample 3, and a write completion shows on `dirty` at sample 1. For each scenario the bench finds the first sample at which the save indication is high and counts the high samples. It compares both numbers with these figures.

// File: rtl/nv_xfer_pkg.sv
// Package: shared sequencer state encoding for the transfer controller.
package nv_xfer_pkg;
    typedef enum logic [2:0] {
        ST_PWRDN   = 3'd0,
        ST_RESTORE = 3'd1,
        ST_IDLE    = 3'd2,
        ST_GRACE   = 3'd3,
        ST_SAVE    = 3'd4,
        ST_HOLD    = 3'd5
    } xfer_state_t;
endpackage

// File: rtl/nv_line_sync.sv
// Multi-stage synchroniser for the asynchronous shared line.
// Assumes the line idles high; the reset value is therefore 1.
module nv_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/nv_dirty_flag.sv
// Tracks whether any array write completed since the last transfer.
// Assumes clr is a one-cycle strobe from the sequencer; clr outranks set.
module nv_dirty_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Set on write completion, clear at the start of a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (clr) flag <= 1'b0;
        else if (set) flag <= 1'b1;
    end

    // R9
    dirty_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr));
    // R9
    dirty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(set));
endmodule

// File: rtl/nv_xfer_seq.sv
// Transfer sequencer: grace timing, conditional save, post-save hold,
// power-loss handling and automatic restore.
// Assumes req_ok is synchronous and pwr_good is already synchronous.
module nv_xfer_seq
    import nv_xfer_pkg::*;
#(
    parameter int DELAY_CYC   = 4,
    parameter int SAVE_CYC    = 6,
    parameter int RESTORE_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_ok,
    input  logic sw_save,
    input  logic pwr_good,
    input  logic dirty,
    output logic start_xfer,
    output logic wr_en,
    output logic rd_en,
    output logic nv_save,
    output logic nv_restore
);
    localparam int MAXC = (DELAY_CYC > SAVE_CYC) ?
                          ((DELAY_CYC > RESTORE_CYC) ? DELAY_CYC : RESTORE_CYC) :
                          ((SAVE_CYC > RESTORE_CYC) ? SAVE_CYC : RESTORE_CYC);
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DLY_LAST = CW'(DELAY_CYC - 1);
    localparam logic [CW-1:0] SAV_LAST = CW'(SAVE_CYC - 1);
    localparam logic [CW-1:0] RST_LAST = CW'(RESTORE_CYC - 1);

    xfer_state_t st, nxt;
    logic [CW-1:0] cnt;
    logic          cnt_last;

    // Select the terminal count for the timed state in progress.
    always_comb begin
        unique case (st)
            ST_GRACE:   cnt_last = (cnt == DLY_LAST);
            ST_SAVE:    cnt_last = (cnt == SAV_LAST);
            ST_RESTORE: cnt_last = (cnt == RST_LAST);
            default:    cnt_last = 1'b0;
        endcase
    end

    // Next-state decision; power loss overrides every other path.
    always_comb begin
        nxt        = st;
        start_xfer = 1'b0;
        unique case (st)
            ST_PWRDN: if (pwr_good) begin
                nxt = ST_RESTORE; start_xfer = 1'b1;
            end
            ST_RESTORE: if (cnt_last) nxt = ST_IDLE;
            ST_IDLE: begin
                if (sw_save) begin
                    nxt = ST_SAVE; start_xfer = 1'b1;
                end else if (!req_ok) begin
                    nxt = ST_GRACE;
                end
            end
            ST_GRACE: if (cnt_last) begin
                if (dirty) begin
                    nxt = ST_SAVE; start_xfer = 1'b1;
                end else begin
                    nxt = ST_HOLD;
                end
            end
            ST_SAVE: if (cnt_last) nxt = ST_HOLD;
            ST_HOLD: if (req_ok) nxt = ST_IDLE;
            default: nxt = ST_PWRDN;
        endcase
        if (!pwr_good) begin
            nxt        = ST_PWRDN;
            start_xfer = 1'b0;
        end
    end

    // State register; reset behaves as a power-up with restore pending.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_PWRDN;
        else        st <= nxt;
    end

    // Cycle counter, restarted on every state change.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (nxt != st)  cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    // Output decode from the registered state.
    always_comb begin
        wr_en      = (st == ST_IDLE) && req_ok;
        rd_en      = (st == ST_IDLE) || (st == ST_GRACE);
        nv_save    = (st == ST_SAVE);
        nv_restore = (st == ST_RESTORE);
    end

    // R5
    save_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_save) |-> $past(sw_save || dirty));
    // R3
    save_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_save && !cnt_last && pwr_good) |=> nv_save);
    // R2
    restore_follows_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st == ST_PWRDN) && $rose(pwr_good)) |=> nv_restore);
    // R10
    power_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!nv_save && !nv_restore && !wr_en && !rd_en));
    // R7
    no_access_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_save || nv_restore) |-> (!wr_en && !rd_en));
    // R8
    hold_until_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(nv_save) && pwr_good && !req_ok) |=> !wr_en);
endmodule

// File: rtl/nv_xfer_ctrl.sv
// Top: shared-line handshake controller for nonvolatile save/restore.
// The shared line is split into a raw input and an open-drain enable;
// the caller wires them together outside this block.
module nv_xfer_ctrl #(
    parameter int DELAY_CYC   = 4,
    parameter int SAVE_CYC    = 6,
    parameter int RESTORE_CYC = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n_in,
    output logic busy_oe,
    input  logic sw_save,
    input  logic pwr_good,
    input  logic wr_done,
    output logic wr_en,
    output logic rd_en,
    output logic nv_save,
    output logic nv_restore,
    output logic dirty
);
    logic line_s;
    logic start_xfer;

    nv_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (line_n_in),
        .q_sync  (line_s)
    );

    nv_dirty_flag u_dirty (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (wr_done),
        .clr   (start_xfer),
        .flag  (dirty)
    );

    nv_xfer_seq #(
        .DELAY_CYC   (DELAY_CYC),
        .SAVE_CYC    (SAVE_CYC),
        .RESTORE_CYC (RESTORE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_ok     (line_s),
        .sw_save    (sw_save),
        .pwr_good   (pwr_good),
        .dirty      (dirty),
        .start_xfer (start_xfer),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .nv_save    (nv_save),
        .nv_restore (nv_restore)
    );

    // Pull the shared line low for the whole save.
    assign busy_oe = nv_save;

    // R7
    busy_matches_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_oe |-> (!wr_en && !rd_en && !nv_restore));
endmodule

// File: tb/nv_xfer_ctrl_test.sv
module nv_xfer_ctrl_test;
    localparam int D = 4;
    localparam int S = 6;
    localparam int R = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_n = 1'b1;
    logic sw_save = 1'b0;
    logic pwr_good = 1'b0;
    logic wr_done = 1'b0;
    logic busy_oe, wr_en, rd_en, nv_save, nv_restore, dirty;
    logic line_n;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign line_n = ext_n & ~busy_oe;

    nv_xfer_ctrl #(.DELAY_CYC(D), .SAVE_CYC(S), .RESTORE_CYC(R)) uut (
        .clk(clk), .rst_n(rst_n), .line_n_in(line_n), .busy_oe(busy_oe),
        .sw_save(sw_save), .pwr_good(pwr_good), .wr_done(wr_done),
        .wr_en(wr_en), .rd_en(rd_en), .nv_save(nv_save),
        .nv_restore(nv_restore), .dirty(dirty)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Vector fields: {use_sw, make_dirty, exp_save}
    localparam logic [2:0] VEC [4] = '{3'b011, 3'b000, 3'b111, 3'b101};

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int first, cnt;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 wr_en", wr_en, 0);
        chk("R1 rd_en", rd_en, 0);
        chk("R1 restore", nv_restore, 0);
        chk("R1 busy", busy_oe, 0);
        // R2 power-up restore
        pwr_good = 1'b1;
        first = -1; cnt = 0;
        for (int k = 1; k <= R + 1; k++) begin
            tick();
            if (nv_restore) begin cnt++; if (first < 0) first = k; end
        end
        chk("R2 restore start", first, 1);
        chk("R2 restore len", cnt, R);
        chk("R2 wr_en after", wr_en, 1);
        chk("R2 rd_en after", rd_en, 1);

        foreach (VEC[i]) begin
            if (VEC[i][1]) begin
                wr_done = 1'b1; tick(); wr_done = 1'b0;
                chk("R9 dirty set", dirty, 1);
            end
            if (VEC[i][2]) sw_save = 1'b1; else ext_n = 1'b0;
            first = -1; cnt = 0;
            for (int k = 1; k <= 20; k++) begin
                tick();
                sw_save = 1'b0;
                if (busy_oe) begin cnt++; if (first < 0) first = k; end
                if (!VEC[i][2] && k == 4) begin
                    chk("R4 grace wr_en", wr_en, 0);
                    chk("R4 grace rd_en", rd_en, 1);
                end
                if (!VEC[i][2] && k == D + 4) chk("R8 hold rd_en", rd_en, 0);
            end
            if (VEC[i][0]) begin
                chk(VEC[i][2] ? "R6 start" : "R3 start", first, VEC[i][2] ? 1 : D + 3);
                chk(VEC[i][2] ? "R6 len" : "R3 len", cnt, S);
                chk("R7 nv_save", nv_save, 0);
            end else begin
                chk("R5 no save", cnt, 0);
            end
            if (!VEC[i][2]) chk("R8 held wr_en", wr_en, 0);
            ext_n = 1'b1;
            tick(); tick();
            if (!VEC[i][2]) chk("R8 wr_en early", wr_en, 0);
            tick();
            chk("R8 wr_en back", wr_en, 1);
            chk("R9 dirty after", dirty, 0);
        end

        // R4 write finishing during grace makes the save happen
        ext_n = 1'b0;
        first = -1; cnt = 0;
        for (int k = 1; k <= 20; k++) begin
            tick();
            wr_done = (k == 4);
            if (nv_save) begin cnt++; if (first < 0) first = k; end
        end
        chk("R4 late write start", first, D + 3);
        chk("R4 late write len", cnt, S);
        ext_n = 1'b1;
        repeat (4) tick();

        // R10 power loss during a save, then restore clears dirty
        wr_done = 1'b1; tick(); wr_done = 1'b0;
        sw_save = 1'b1; tick(); sw_save = 1'b0;
        chk("R6 save on", nv_save, 1);
        wr_done = 1'b1; tick(); wr_done = 1'b0;
        pwr_good = 1'b0; tick();
        chk("R10 save aborted", nv_save, 0);
        chk("R10 busy off", busy_oe, 0);
        chk("R10 wr_en off", wr_en, 0);
        chk("R9 dirty kept", dirty, 1);
        pwr_good = 1'b1; tick();
        chk("R10 restore", nv_restore, 1);
        chk("R9 dirty cleared by restore", dirty, 0);
        repeat (R) tick();
        chk("R2 idle after restore", rd_en, 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule